// File: doc/BRIEF.md
# Two-Way Data Cache with Single-Entry Store Buffer

This block is the data-side cache of a load/store unit. It holds 16KB in two ways of 256 sets, with 32-byte lines organised as four 64-bit doublewords. The set and doubleword are picked by untranslated index bits, and the physical tag is compared in the same cycle, so address translation runs alongside the array access. Loads return a full doubleword one cycle after they are presented. Stores carry a byte mask.

A store that hits is parked in a one-entry store buffer during its tag compare. The buffer is written into the data array later, in a cycle in which no load needs the array. This keeps stores flowing at one per cycle. A load that reads the doubleword sitting in the buffer sees the buffered bytes merged into its result. Write-back is the default policy. A per-store write-through flag also sends the store out on a write port.

Line refill is performed by an external sequencer through a doubleword fill port. When a load misses, the block reports the victim way and, if that line is dirty, a writeback request. Every data byte and every tag carries a parity bit.

Top module: `dcache`

## Requirements
- R1: The set index is taken from `ld_idx[9:2]` / `st_idx[9:2]` and the doubleword from bits `[1:0]`. A load is accepted when `ld_req` is high and `ld_stall` is low. For an accepted load, the cycle after it shows `rsp_valid`=1. `rsp_hit`=1 is shown when either way is valid and holds `ld_ptag`. On a hit, `rsp_data` is the stored doubleword. A cycle with no accepted load shows `rsp_valid`=0 in the next cycle.
- R2: A load miss reports the victim in the same cycle as `rsp_valid`. The victim way is the per-set replacement bit, which points away from the way most recently filled or load-hit. If that way is valid and dirty, `victim_wb`=1 with its tag and set; otherwise `victim_wb`=0.
- R3: A store hit is captured in the store buffer in its own cycle. It is written into the data array at the end of the first later cycle that has no load request, or that has a new store.
- R4: A hitting load to the same way, set and doubleword as the buffered store returns the stored bytes with the buffered bytes (where the buffer's byte mask is 1) replacing them.
- R5: Stores are accepted every cycle with no stall. A new store that arrives while the buffer holds an entry writes that entry into the array in the same cycle.
- R6: `ld_stall` is 1 exactly when a load and a store are presented together while the buffer holds an entry. A stalled load produces no response. With an empty buffer, a load and a store in the same cycle both proceed.
- R7: A write-back store hit marks the line dirty. A store with `st_wthru`=1 leaves the dirty bit unchanged and, one cycle later, drives `wt_valid`=1 with `wt_addr`={tag, index, 3'b000}, `wt_data` and `wt_be`. This happens whether the store hits or misses.
- R8: A store miss drives `st_miss`=1 one cycle later and changes no line contents.
- R9: Byte parity and tag parity are generated on every array write and checked on every load hit. `rsp_perr` flags a mismatch and stays 0 for data written through the ports.
- R10: After reset all lines are invalid, and every registered output is 0.
- R11: A fill write stores one doubleword, installs the tag, marks the line valid and clean, and moves the set's replacement bit to the other way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 1 | Load request |
| ld_idx | input | 10 | Load set and doubleword index |
| ld_ptag | input | 19 | Load physical tag |
| st_req | input | 1 | Store request |
| st_idx | input | 10 | Store set and doubleword index |
| st_ptag | input | 19 | Store physical tag |
| st_data | input | 64 | Store data |
| st_be | input | 8 | Store byte mask |
| st_wthru | input | 1 | Write-through attribute of this store |
| fill_we | input | 1 | Fill write strobe |
| fill_way | input | 1 | Fill target way |
| fill_set | input | 8 | Fill target set |
| fill_dw | input | 2 | Fill doubleword within line |
| fill_tag | input | 19 | Tag installed by the fill |
| fill_data | input | 64 | Fill doubleword |
| ld_stall | output | 1 | Load presented this cycle is not accepted |
| rsp_valid | output | 1 | Load response valid |
| rsp_hit | output | 1 | Load hit |
| rsp_data | output | 64 | Load data (zero on miss) |
| rsp_perr | output | 1 | Parity error on the hit |
| victim_wb | output | 1 | Dirty victim needs writeback |
| victim_way | output | 1 | Victim way for the missing load |
| victim_set | output | 8 | Victim set |
| victim_tag | output | 19 | Victim tag |
| st_miss | output | 1 | Previous store missed |
| wt_valid | output | 1 | Write-through store out |
| wt_addr | output | 32 | Write-through physical address |
| wt_data | output | 64 | Write-through data |
| wt_be | output | 8 | Write-through byte mask |

## Verification
A stuck or lost store buffer entry shows up on the first load of that doubleword. If the buffer is still held, forwarding returns the merged value. If it has drained, a later load reads the array value. A missed drain gives old data one cycle after the load is presented. A wrong dirty or replacement bit shows only on the next load miss to that set, through `victim_wb` and `victim_way`. The tests therefore force such a miss right after each store and fill pattern. A wrong stall decision is visible combinationally in the same cycle, and as a missing or extra `rsp_valid` one cycle later.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
    parameter int CACHE_BYTES = 16384;
    parameter int LINE_BYTES  = 32;
    parameter int NUM_WAYS    = 2;   // replacement state is one bit per set
    parameter int DATA_W      = 64;
    parameter int PADDR_W     = 32;

    localparam int BE_W     = DATA_W / 8;
    localparam int BOFF_W   = $clog2(BE_W);
    localparam int DPL      = LINE_BYTES / BE_W;
    localparam int DW_W     = $clog2(DPL);
    localparam int NUM_SETS = CACHE_BYTES / (NUM_WAYS * LINE_BYTES);
    localparam int SET_W    = $clog2(NUM_SETS);
    localparam int IDX_W    = SET_W + DW_W;
    localparam int TAG_W    = PADDR_W - IDX_W - BOFF_W;
    localparam int WAY_W    = $clog2(NUM_WAYS);

    typedef logic [DATA_W-1:0] dword_t;
    typedef logic [BE_W-1:0]   bmask_t;
    typedef logic [SET_W-1:0]  set_t;
    typedef logic [DW_W-1:0]   dwsel_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [WAY_W-1:0]  way_t;

    typedef struct packed {
        dword_t data;
        bmask_t par;
    } dentry_t;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic tpar;
        tag_t tag;
    } tagent_t;

    typedef struct packed {
        logic   valid;
        way_t   way;
        set_t   set;
        dwsel_t dw;
        dword_t data;
        bmask_t be;
    } sbuf_t;

    function automatic bmask_t byte_parity(input dword_t d);
        bmask_t p;
        for (int b = 0; b < BE_W; b++) p[b] = ^d[b*8 +: 8];
        return p;
    endfunction

    function automatic dword_t merge_bytes(input dword_t base, input dword_t upd, input bmask_t be);
        dword_t r;
        for (int b = 0; b < BE_W; b++) r[b*8 +: 8] = be[b] ? upd[b*8 +: 8] : base[b*8 +: 8];
        return r;
    endfunction

    function automatic set_t idx_set(input idx_t i);
        return i[IDX_W-1 -: SET_W];
    endfunction

    function automatic dwsel_t idx_dw(input idx_t i);
        return i[DW_W-1:0];
    endfunction
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store
    import dcache_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  set_t    ld_set,
    input  tag_t    ld_ptag,
    output tagent_t ld_ent [NUM_WAYS],
    output logic [NUM_WAYS-1:0] ld_hit_w,
    output way_t    ld_repl,
    input  set_t    st_set,
    input  tag_t    st_ptag,
    output logic [NUM_WAYS-1:0] st_hit_w,
    input  logic    fill_we,
    input  way_t    fill_way,
    input  set_t    fill_set,
    input  tag_t    fill_tag,
    input  logic    dirty_we,
    input  way_t    dirty_way,
    input  set_t    dirty_set,
    input  logic    touch_we,
    input  way_t    touch_way,
    input  set_t    touch_set
);
    logic [NUM_SETS-1:0] repl_q;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        tag_t tags [NUM_SETS];
        logic tpar [NUM_SETS];
        logic [NUM_SETS-1:0] valid_q;
        logic [NUM_SETS-1:0] dirty_q;
        logic fill_here;

        assign fill_here = fill_we && (fill_way == way_t'(w));

        always_ff @(posedge clk) begin
            if (fill_here) begin
                tags[fill_set] <= fill_tag;
                tpar[fill_set] <= ^fill_tag;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= '0;
                dirty_q <= '0;
            end else begin
                if (dirty_we && dirty_way == way_t'(w)) dirty_q[dirty_set] <= 1'b1;
                if (fill_here) begin
                    valid_q[fill_set] <= 1'b1;
                    dirty_q[fill_set] <= 1'b0;
                end
            end
        end

        assign ld_ent[w]   = '{valid: valid_q[ld_set], dirty: dirty_q[ld_set],
                               tpar: tpar[ld_set], tag: tags[ld_set]};
        assign ld_hit_w[w] = valid_q[ld_set] && (tags[ld_set] == ld_ptag);
        assign st_hit_w[w] = valid_q[st_set] && (tags[st_set] == st_ptag);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            repl_q <= '0;
        end else begin
            if (touch_we) repl_q[touch_set] <= ~touch_way[0];
            if (fill_we)  repl_q[fill_set]  <= ~fill_way[0];
        end
    end

    assign ld_repl = way_t'(repl_q[ld_set]);
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store
    import dcache_pkg::*;
(
    input  logic    clk,
    input  set_t    rd_set,
    input  dwsel_t  rd_dw,
    output dentry_t rd_q [NUM_WAYS],
    input  logic    fill_we,
    input  way_t    fill_way,
    input  set_t    fill_set,
    input  dwsel_t  fill_dw,
    input  dword_t  fill_data,
    input  logic    drain_we,
    input  way_t    drain_way,
    input  set_t    drain_set,
    input  dwsel_t  drain_dw,
    input  dword_t  drain_data,
    input  bmask_t  drain_be
);
    localparam int DEPTH = NUM_SETS * DPL;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        dentry_t mem [DEPTH];

        always_ff @(posedge clk) begin
            if (fill_we && fill_way == way_t'(w))
                mem[{fill_set, fill_dw}] <= '{data: fill_data, par: byte_parity(fill_data)};
            if (drain_we && drain_way == way_t'(w)) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (drain_be[b]) begin
                        mem[{drain_set, drain_dw}].data[b*8 +: 8] <= drain_data[b*8 +: 8];
                        mem[{drain_set, drain_dw}].par[b]         <= ^drain_data[b*8 +: 8];
                    end
                end
            end
        end

        assign rd_q[w] = mem[{rd_set, rd_dw}];
    end
endmodule

// File: rtl/dc_store_buf.sv
module dc_store_buf
    import dcache_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ld_req,
    input  logic  st_req,
    input  logic  cap_en,
    input  sbuf_t cap_ent,
    output sbuf_t held,
    output logic  drain,
    output logic  ld_stall
);
    // A held entry goes to the array when the array is free of loads,
    // or when a newer store needs the slot (then a concurrent load waits).
    assign drain    = held.valid && (st_req || !ld_req);
    assign ld_stall = held.valid && st_req && ld_req;

    always_ff @(posedge clk) begin
        if (rst)         held       <= '0;
        else if (cap_en) held       <= cap_ent;
        else if (drain)  held.valid <= 1'b0;
    end
endmodule

// File: rtl/dcache.sv
module dcache
    import dcache_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_req,
    input  logic [IDX_W-1:0]   ld_idx,
    input  logic [TAG_W-1:0]   ld_ptag,
    input  logic               st_req,
    input  logic [IDX_W-1:0]   st_idx,
    input  logic [TAG_W-1:0]   st_ptag,
    input  logic [DATA_W-1:0]  st_data,
    input  logic [BE_W-1:0]    st_be,
    input  logic               st_wthru,
    input  logic               fill_we,
    input  logic [WAY_W-1:0]   fill_way,
    input  logic [SET_W-1:0]   fill_set,
    input  logic [DW_W-1:0]    fill_dw,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [DATA_W-1:0]  fill_data,
    output logic               ld_stall,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               rsp_perr,
    output logic               victim_wb,
    output logic [WAY_W-1:0]   victim_way,
    output logic [SET_W-1:0]   victim_set,
    output logic [TAG_W-1:0]   victim_tag,
    output logic               st_miss,
    output logic               wt_valid,
    output logic [PADDR_W-1:0] wt_addr,
    output logic [DATA_W-1:0]  wt_data,
    output logic [BE_W-1:0]    wt_be
);
    set_t   ld_set, st_set;
    dwsel_t ld_dw, st_dw;
    assign ld_set = idx_set(ld_idx);
    assign ld_dw  = idx_dw(ld_idx);
    assign st_set = idx_set(st_idx);
    assign st_dw  = idx_dw(st_idx);

    tagent_t             ld_ent [NUM_WAYS];
    logic [NUM_WAYS-1:0] ld_hit_w, st_hit_w;
    way_t                ld_repl, ld_way, st_way;
    dentry_t             dq [NUM_WAYS];
    sbuf_t               held, cap_ent;
    logic                drain, ld_acc, ld_hit, st_hit, fwd, perr, victim_need;
    dword_t              ld_word;
    dentry_t             ld_dent;
    tagent_t             ld_tent, vent;

    always_comb begin
        ld_way = '0;
        st_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (ld_hit_w[w]) ld_way = way_t'(w);
            if (st_hit_w[w]) st_way = way_t'(w);
        end
    end

    assign ld_hit = |ld_hit_w;
    assign st_hit = |st_hit_w;
    assign ld_acc = ld_req && !ld_stall;

    assign cap_ent = '{valid: 1'b1, way: st_way, set: st_set, dw: st_dw,
                       data: st_data, be: st_be};

    dc_tag_store u_tags (
        .clk       (clk),
        .rst       (rst),
        .ld_set    (ld_set),
        .ld_ptag   (ld_ptag),
        .ld_ent    (ld_ent),
        .ld_hit_w  (ld_hit_w),
        .ld_repl   (ld_repl),
        .st_set    (st_set),
        .st_ptag   (st_ptag),
        .st_hit_w  (st_hit_w),
        .fill_we   (fill_we),
        .fill_way  (fill_way),
        .fill_set  (fill_set),
        .fill_tag  (fill_tag),
        .dirty_we  (st_req && st_hit && !st_wthru),
        .dirty_way (st_way),
        .dirty_set (st_set),
        .touch_we  (ld_acc && ld_hit),
        .touch_way (ld_way),
        .touch_set (ld_set)
    );

    dc_data_store u_data (
        .clk        (clk),
        .rd_set     (ld_set),
        .rd_dw      (ld_dw),
        .rd_q       (dq),
        .fill_we    (fill_we),
        .fill_way   (fill_way),
        .fill_set   (fill_set),
        .fill_dw    (fill_dw),
        .fill_data  (fill_data),
        .drain_we   (drain),
        .drain_way  (held.way),
        .drain_set  (held.set),
        .drain_dw   (held.dw),
        .drain_data (held.data),
        .drain_be   (held.be)
    );

    dc_store_buf u_sbuf (
        .clk      (clk),
        .rst      (rst),
        .ld_req   (ld_req),
        .st_req   (st_req),
        .cap_en   (st_req && st_hit),
        .cap_ent  (cap_ent),
        .held     (held),
        .drain    (drain),
        .ld_stall (ld_stall)
    );

    assign ld_dent = dq[ld_way];
    assign ld_tent = ld_ent[ld_way];
    assign vent    = ld_ent[ld_repl];

    assign fwd     = held.valid && ld_hit && (held.way == ld_way)
                     && (held.set == ld_set) && (held.dw == ld_dw);
    assign ld_word = fwd ? merge_bytes(ld_dent.data, held.data, held.be) : ld_dent.data;
    assign perr    = ld_hit && ((byte_parity(ld_dent.data) != ld_dent.par)
                                || ((^ld_tent.tag) != ld_tent.tpar));
    assign victim_need = ld_acc && !ld_hit && vent.valid && vent.dirty;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_data   <= '0;
            rsp_perr   <= 1'b0;
            victim_wb  <= 1'b0;
            victim_way <= '0;
            victim_set <= '0;
            victim_tag <= '0;
            st_miss    <= 1'b0;
            wt_valid   <= 1'b0;
            wt_addr    <= '0;
            wt_data    <= '0;
            wt_be      <= '0;
        end else begin
            rsp_valid  <= ld_acc;
            rsp_hit    <= ld_acc && ld_hit;
            rsp_data   <= (ld_acc && ld_hit) ? ld_word : '0;
            rsp_perr   <= ld_acc && perr;
            victim_wb  <= victim_need;
            victim_way <= ld_repl;
            victim_set <= ld_set;
            victim_tag <= victim_need ? vent.tag : '0;
            st_miss    <= st_req && !st_hit;
            wt_valid   <= st_req && st_wthru;
            wt_addr    <= {st_ptag, st_idx, {BOFF_W{1'b0}}};
            wt_data    <= st_data;
            wt_be      <= st_be;
        end
    end
endmodule

// File: rtl/dcache_sva.sv
module dcache_sva
    import dcache_pkg::*;
(
    input logic         clk,
    input logic         rst,
    input logic         ld_req,
    input logic         st_req,
    input logic         st_wthru,
    input logic [DATA_W-1:0] st_data,
    input logic         ld_stall,
    input logic         rsp_valid,
    input logic         rsp_hit,
    input logic         victim_wb,
    input logic         st_miss,
    input logic         wt_valid,
    input logic [DATA_W-1:0] wt_data
);
    assert_stall_cause_R6: assert property (@(posedge clk) disable iff (rst)
        ld_stall |-> (ld_req && st_req));

    assert_stalled_silent_R6: assert property (@(posedge clk) disable iff (rst)
        ld_stall |=> !rsp_valid);

    assert_load_answered_R1: assert property (@(posedge clk) disable iff (rst)
        (ld_req && !ld_stall) |=> rsp_valid);

    assert_no_spurious_rsp_R1: assert property (@(posedge clk) disable iff (rst)
        !ld_req |=> !rsp_valid);

    assert_victim_on_miss_R2: assert property (@(posedge clk) disable iff (rst)
        victim_wb |-> (rsp_valid && !rsp_hit));

    assert_wt_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (st_req && st_wthru) |=> (wt_valid && wt_data == $past(st_data)));

    assert_wt_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !(st_req && st_wthru) |=> !wt_valid);

    assert_miss_from_store_R8: assert property (@(posedge clk) disable iff (rst)
        st_miss |-> $past(st_req));
endmodule

bind dcache dcache_sva u_sva (.*);

// File: tb/tb_dcache.sv
module tb_dcache;
    import dcache_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic ld_req = 0, st_req = 0, st_wthru = 0, fill_we = 0;
    idx_t ld_idx = '0, st_idx = '0;
    tag_t ld_ptag = '0, st_ptag = '0, fill_tag = '0;
    dword_t st_data = '0, fill_data = '0;
    bmask_t st_be = '0;
    way_t fill_way = '0;
    set_t fill_set = '0;
    dwsel_t fill_dw = '0;
    logic ld_stall, rsp_valid, rsp_hit, rsp_perr, victim_wb, st_miss, wt_valid;
    dword_t rsp_data, wt_data;
    way_t victim_way;
    set_t victim_set;
    tag_t victim_tag;
    logic [PADDR_W-1:0] wt_addr;
    bmask_t wt_be;

    dcache dut (.*);

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam tag_t TA = 19'h01A2B, TB = 19'h02C3D, TC = 19'h30F0F, TD = 19'h11111,
                     TE = 19'h22222, TF = 19'h33333, TG = 19'h44444, TH = 19'h55555;

    function automatic dword_t pat(input tag_t t, input int d);
        return {t[15:0], 16'h5A5A, 14'h0, 2'(d), 16'hBEEF};
    endfunction

    function automatic idx_t mk_idx(input int s, input int d);
        return {set_t'(s), dwsel_t'(d)};
    endfunction

    function automatic dword_t exp_merge(input dword_t a, input dword_t b, input bmask_t m);
        dword_t r = a;
        for (int i = 0; i < BE_W; i++) if (m[i]) r[i*8 +: 8] = b[i*8 +: 8];
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic go();
        @(negedge clk);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        ld_req = 0; st_req = 0; fill_we = 0; st_wthru = 0;
    endtask

    task automatic set_load(input int s, input int d, input tag_t t);
        ld_req = 1; ld_idx = mk_idx(s, d); ld_ptag = t;
    endtask

    task automatic set_store(input int s, input int d, input tag_t t, input dword_t v,
                             input bmask_t m, input logic wt);
        st_req = 1; st_idx = mk_idx(s, d); st_ptag = t; st_data = v; st_be = m; st_wthru = wt;
    endtask

    task automatic fill_line(input logic w, input int s, input tag_t t);
        for (int d = 0; d < DPL; d++) begin
            go();
            fill_we = 1; fill_way = way_t'(w); fill_set = set_t'(s);
            fill_dw = dwsel_t'(d); fill_tag = t; fill_data = pat(t, d);
            tick();
        end
    endtask

    task automatic load_expect(input string req, input int s, input int d, input tag_t t,
                               input logic hit, input dword_t v);
        go(); set_load(s, d, t); tick();
        chk(req, "rsp_valid", rsp_valid, 1);
        chk(req, "rsp_hit", rsp_hit, hit);
        if (hit) chk(req, "rsp_data", rsp_data, v);
        chk("R9", "rsp_perr", rsp_perr, 0);
    endtask

    task automatic idle();
        go(); tick();
    endtask

    task automatic t_reset();
        chk("R10", "rsp_valid", rsp_valid, 0);
        chk("R10", "victim_wb", victim_wb, 0);
        chk("R10", "wt_valid", wt_valid, 0);
        chk("R10", "st_miss", st_miss, 0);
        load_expect("R10", 5, 0, TA, 0, '0);
    endtask

    task automatic t_fill_load();
        fill_line(0, 10, TA);
        load_expect("R11", 10, 2, TA, 1, pat(TA, 2));
        load_expect("R1", 10, 3, TA, 1, pat(TA, 3));
        load_expect("R1", 10, 3, TB, 0, '0);
    endtask

    task automatic t_store_forward();
        dword_t x = 64'h1122_3344_5566_7788;
        go(); set_store(10, 1, TA, x, 8'h0F, 0); tick();
        chk("R8", "st_miss after hit", st_miss, 0);
        load_expect("R4", 10, 1, TA, 1, exp_merge(pat(TA, 1), x, 8'h0F));
        idle();
        load_expect("R3", 10, 1, TA, 1, exp_merge(pat(TA, 1), x, 8'h0F));
    endtask

    task automatic t_victim();
        fill_line(1, 10, TB);
        go(); set_load(10, 0, TC); tick();
        chk("R2", "dirty victim_wb", victim_wb, 1);
        chk("R2", "victim_way", victim_way, 0);
        chk("R2", "victim_tag", victim_tag, TA);
        chk("R2", "victim_set", victim_set, 10);
        fill_line(0, 20, TA);
        go(); set_load(20, 0, TC); tick();
        chk("R2", "clean victim_wb", victim_wb, 0);
        chk("R2", "victim_way invalid", victim_way, 1);
    endtask

    task automatic t_write_through();
        dword_t y = 64'hCAFE_F00D_DEAD_0001;
        fill_line(0, 30, TD);
        go(); set_store(30, 0, TD, y, 8'hFF, 1); tick();
        chk("R7", "wt_valid", wt_valid, 1);
        chk("R7", "wt_addr", wt_addr, {TD, mk_idx(30, 0), 3'b000});
        chk("R7", "wt_data", wt_data, y);
        chk("R7", "wt_be", wt_be, 8'hFF);
        idle();
        chk("R7", "wt_valid drops", wt_valid, 0);
        load_expect("R7", 30, 0, TD, 1, y);
        fill_line(1, 30, TF);
        go(); set_load(30, 1, TE); tick();
        chk("R7", "wt line stays clean", victim_wb, 0);
        chk("R7", "victim way0", victim_way, 0);
    endtask

    task automatic t_store_miss();
        go(); set_store(40, 0, TG, 64'h7, 8'hFF, 0); tick();
        chk("R8", "st_miss", st_miss, 1);
        chk("R8", "no wt on wb miss", wt_valid, 0);
        load_expect("R8", 40, 0, TG, 0, '0);
        go(); set_store(40, 1, TG, 64'h9, 8'h01, 1); tick();
        chk("R7", "wt on miss", wt_valid, 1);
        chk("R8", "st_miss wt", st_miss, 1);
    endtask

    task automatic t_back_to_back();
        dword_t v0 = 64'h0000_0000_AAAA_0000, v1 = 64'h1111_0000_BBBB_0000,
                v2 = 64'h2222_0000_CCCC_0000, v3 = 64'h3333_0000_DDDD_0000,
                w = 64'h4444_0000_EEEE_0000, z = 64'h5555_0000_FFFF_0000;
        fill_line(0, 50, TH);
        go(); set_store(50, 0, TH, v0, 8'hFF, 0); #1;
        chk("R5", "no stall s0", ld_stall, 0); tick();
        go(); set_store(50, 1, TH, v1, 8'hFF, 0); #1;
        chk("R5", "no stall s1", ld_stall, 0); tick();
        go(); set_store(50, 2, TH, v2, 8'hFF, 0); tick();
        chk("R5", "st_miss b2b", st_miss, 0);
        idle();
        load_expect("R5", 50, 0, TH, 1, v0);
        load_expect("R5", 50, 1, TH, 1, v1);
        load_expect("R5", 50, 2, TH, 1, v2);
        go(); set_store(50, 3, TH, v3, 8'hFF, 0); tick();
        go(); set_store(50, 0, TH, w, 8'hFF, 0); set_load(50, 1, TH); #1;
        chk("R6", "ld_stall with held entry", ld_stall, 1);
        tick();
        chk("R6", "stalled load no rsp", rsp_valid, 0);
        load_expect("R5", 50, 3, TH, 1, v3);
        load_expect("R4", 50, 0, TH, 1, w);
        idle();
        go(); set_store(50, 1, TH, z, 8'hFF, 0); set_load(50, 2, TH); #1;
        chk("R6", "no stall empty buffer", ld_stall, 0);
        tick();
        chk("R6", "load proceeds", rsp_valid, 1);
        chk("R6", "load data", rsp_data, v2);
        idle();
        load_expect("R3", 50, 1, TH, 1, z);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_fill_load();
        t_store_forward();
        t_victim();
        t_write_through();
        t_store_miss();
        t_back_to_back();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule